// File: doc/BRIEF.md
# Reset Supervisor with Watchdog Pulse Train

This block drives an active-low reset line for a host processor. It watches two synchronous supply-comparator flags: one says the supply is above the lower threshold, the other says it is above the upper threshold. It also watches a watchdog line that the host toggles. Reset is held low while the supply is low. It is released only after the supply climbs past the upper threshold and a programmable number of clock cycles has passed.

Once reset is released, the host must make a falling edge on the watchdog line within the same programmable cycle count. If it does not, the block produces a square wave on the reset line: low for the count, high for the count, repeating. The wave stops when a falling edge arrives. One counter times the power-up delay, the watchdog window and both halves of the pulse train. The delay input is a cycle count, and a value of zero behaves as one cycle.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_clr_n` is low, `rst_n_out` is low, with no wait for a clock edge. After the clear is released, the block starts in the undervoltage state: reset stays low until a full power-up delay completes.
- R2: A clock edge that samples `sup_lo_ok` low drives `rst_n_out` low from that edge on. This holds from any state.
- R3: Hysteresis between the two flags. After an undervoltage, reset stays low while `sup_lo_ok`=1 and `sup_hi_ok`=0. Once reset is released, `sup_hi_ok` falling alone has no effect on the reset line.
- R4: Power-up delay. Let N be the effective delay. Reset rises at the (N+1)-th rising edge after the first edge that samples `sup_hi_ok` high with `sup_lo_ok` high. A bench sampling at falling edges therefore sees N+1 low samples, counting the sample on which the flag is driven.
- R5: The effective delay N equals `delay_cnt`, except that `delay_cnt`=0 gives N=1.
- R6: After reset is released, if no valid watchdog edge occurs, reset stays high for exactly N cycles and then goes low.
- R7: After a timeout, reset is a square wave: low for N cycles, then high for N cycles, repeating, with a period of 2N cycles.
- R8: Only a 1-to-0 transition of `wdog_in` services the watchdog. A held low level and a 0-to-1 transition change neither the timeout nor the pulse train.
- R9: `wdog_in` passes through two synchronizer flops. A falling edge driven between rising edges k and k+1 takes effect at rising edge k+3, and it restarts the N-cycle window from there.
- R10: A valid falling edge that takes effect while the pulse train holds reset low returns reset high at that same edge. Reset then stays high for a fresh N cycles.
- R11: An undervoltage during the pulse train overrides it. After the supply recovers, the full power-up delay (N+1 low samples as in R4) is applied again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_clr_n | input | 1 | Asynchronous power-up clear, active low |
| sup_lo_ok | input | 1 | Supply above lower threshold (synchronous) |
| sup_hi_ok | input | 1 | Supply above upper threshold (synchronous) |
| wdog_in | input | 1 | Watchdog service line from host; idles high |
| delay_cnt | input | DLY_W | Delay in cycles for power-up, watchdog window and pulse halves |
| rst_n_out | output | 1 | Active-low reset to the host |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an undervoltage and a pulse-train transition: the bench drops `sup_lo_ok` in the middle of a low half of the train. It then expects the full power-up length again, not the remainder of the pulse. The second pair is a synchronized watchdog edge and the start of a pulse-low half. The bench drives the falling edge on the very sample where reset first goes low. It then expects reset to stay low for exactly two more samples, return high on the third, and stay high for a whole new window.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic [2:0] {
    ST_UNDERV   = 3'd0,
    ST_POR      = 3'd1,
    ST_RUN      = 3'd2,
    ST_PULSE_LO = 3'd3,
    ST_PULSE_HI = 3'd4
  } sup_state_e;

  // reset line level that belongs to a state
  function automatic logic state_rst_level(sup_state_e st);
    return (st == ST_RUN) || (st == ST_PULSE_HI);
  endfunction
endpackage

// File: rtl/rst_sup_wdog_sync.sv
module rst_sup_wdog_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic wdog_raw,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle level is high (pulled up when undriven)
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wdog_raw};
      prev_q <= sync_q[LAST];
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    fall_o |=> !fall_o); // R8
endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             restart,
  input  logic [DLY_W-1:0] limit_raw,
  output logic             last_o
);
  localparam logic [DLY_W:0] ONE_X = {{DLY_W{1'b0}}, 1'b1};

  // zero is treated as a single cycle
  function automatic logic [DLY_W:0] eff_limit(input logic [DLY_W-1:0] raw);
    return (raw == '0) ? ONE_X : {1'b0, raw};
  endfunction

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W:0]   cnt_next_x;

  assign cnt_next_x = {1'b0, cnt_q} + ONE_X;
  assign last_o     = cnt_next_x >= eff_limit(limit_raw);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!last_o)  cnt_q <= cnt_next_x[DLY_W-1:0];
  end
endmodule

// File: rtl/rst_sup_fsm.sv
module rst_sup_fsm
  import rst_sup_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic sup_lo_ok,
  input  logic sup_hi_ok,
  input  logic wd_fall,
  input  logic tmr_last,
  output logic tmr_restart,
  output logic rst_n_o
);
  sup_state_e st_q, st_d;
  logic       rst_q;

  always_comb begin
    st_d        = st_q;
    tmr_restart = 1'b0;
    if (!sup_lo_ok) begin
      st_d        = ST_UNDERV;
      tmr_restart = 1'b1;
    end else begin
      case (st_q)
        ST_UNDERV: begin
          tmr_restart = 1'b1;
          if (sup_hi_ok) st_d = ST_POR;
        end
        ST_POR: if (tmr_last) begin
          st_d        = ST_RUN;
          tmr_restart = 1'b1;
        end
        ST_RUN: if (wd_fall || tmr_last) begin
          tmr_restart = 1'b1;
          if (!wd_fall) st_d = ST_PULSE_LO;
        end
        ST_PULSE_LO: if (wd_fall) begin
          st_d        = ST_RUN;
          tmr_restart = 1'b1;
        end else if (tmr_last) begin
          st_d        = ST_PULSE_HI;
          tmr_restart = 1'b1;
        end
        ST_PULSE_HI: if (wd_fall) begin
          st_d        = ST_RUN;
          tmr_restart = 1'b1;
        end else if (tmr_last) begin
          st_d        = ST_PULSE_LO;
          tmr_restart = 1'b1;
        end
        default: begin
          st_d        = ST_UNDERV;
          tmr_restart = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_UNDERV;
      rst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rst_q <= state_rst_level(st_d);
    end
  end

  assign rst_n_o = rst_q;

  AST_UV_FORCES_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_lo_ok |=> !rst_n_o); // R2
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_UNDERV && !sup_hi_ok) |=> !rst_n_o); // R3
  AST_RISE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(sup_lo_ok)); // R4
  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_RUN && tmr_last && !wd_fall && sup_lo_ok) |=> !rst_n_o); // R6
  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!arst_n)
    ((st_q == ST_PULSE_LO || st_q == ST_PULSE_HI) && tmr_last && !wd_fall && sup_lo_ok)
      |=> (rst_n_o != $past(rst_n_o))); // R7
  AST_KICK_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_PULSE_LO && wd_fall && sup_lo_ok) |=> rst_n_o); // R10
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_clr_n,
  input  logic             sup_lo_ok,
  input  logic             sup_hi_ok,
  input  logic             wdog_in,
  input  logic [DLY_W-1:0] delay_cnt,
  output logic             rst_n_out
);
  logic wd_fall;
  logic tmr_last;
  logic tmr_restart;

  rst_sup_wdog_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst_n   (por_clr_n),
    .wdog_raw (wdog_in),
    .fall_o   (wd_fall)
  );

  rst_sup_timer #(.DLY_W(DLY_W)) u_timer (
    .clk       (clk),
    .arst_n    (por_clr_n),
    .restart   (tmr_restart),
    .limit_raw (delay_cnt),
    .last_o    (tmr_last)
  );

  rst_sup_fsm u_fsm (
    .clk         (clk),
    .arst_n      (por_clr_n),
    .sup_lo_ok   (sup_lo_ok),
    .sup_hi_ok   (sup_hi_ok),
    .wd_fall     (wd_fall),
    .tmr_last    (tmr_last),
    .tmr_restart (tmr_restart),
    .rst_n_o     (rst_n_out)
  );

  AST_CLEAR_LOW: assert property (@(posedge clk) !por_clr_n |-> !rst_n_out); // R1
endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 16;
  localparam int NVEC       = 5;
  localparam int VEC_DLY [NVEC] = '{5, 1, 0, 3, 8};
  localparam int VEC_EXP [NVEC] = '{5, 1, 1, 3, 8};

  logic             clk = 1'b0;
  logic             por_clr_n;
  logic             sup_lo_ok;
  logic             sup_hi_ok;
  logic             wdog_in;
  logic [DLY_W-1:0] delay_cnt;
  logic             rst_n_out;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.DLY_W(DLY_W)) dut_i (
    .clk       (clk),
    .por_clr_n (por_clr_n),
    .sup_lo_ok (sup_lo_ok),
    .sup_hi_ok (sup_hi_ok),
    .wdog_in   (wdog_in),
    .delay_cnt (delay_cnt),
    .rst_n_out (rst_n_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // number of consecutive falling-edge samples equal to the current one
  task automatic run_len(output int len);
    logic v;
    v   = rst_n_out;
    len = 0;
    while (rst_n_out == v && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  initial begin
    int len;
    bit ok;
    por_clr_n = 1'b0;
    sup_lo_ok = 1'b0;
    sup_hi_ok = 1'b0;
    wdog_in   = 1'b1;
    delay_cnt = DLY_W'(5);
    step(3);
    chk(rst_n_out == 1'b0, "R1 held in clear", int'(rst_n_out), 0);
    por_clr_n = 1'b1;
    step(4);
    chk(rst_n_out == 1'b0, "R1 after clear", int'(rst_n_out), 0);

    // vector table: power-up length, window, then two pulse halves
    for (int i = 0; i < NVEC; i++) begin
      sup_lo_ok = 1'b0;
      sup_hi_ok = 1'b0;
      delay_cnt = DLY_W'(VEC_DLY[i]);
      step(1);
      chk(rst_n_out == 1'b0, "R2 undervoltage", int'(rst_n_out), 0);
      sup_lo_ok = 1'b1;
      sup_hi_ok = 1'b1;
      run_len(len);
      chk(len == VEC_EXP[i] + 1, "R4 R5 power-up low", len, VEC_EXP[i] + 1);
      run_len(len);
      chk(len == VEC_EXP[i], "R6 window high", len, VEC_EXP[i]);
      run_len(len);
      chk(len == VEC_EXP[i], "R7 pulse low", len, VEC_EXP[i]);
      run_len(len);
      chk(len == VEC_EXP[i], "R7 pulse high", len, VEC_EXP[i]);
    end

    // R3: between thresholds after undervoltage keeps reset low
    sup_lo_ok = 1'b0;
    sup_hi_ok = 1'b0;
    step(1);
    sup_lo_ok = 1'b1;
    ok = 1'b1;
    for (int j = 0; j < 20; j++) begin
      step(1);
      if (rst_n_out) ok = 1'b0;
    end
    chk(ok, "R3 hold between thresholds", int'(ok), 1);
    sup_hi_ok = 1'b1;
    run_len(len);
    chk(len == 9, "R4 release after upper flag", len, 9);
    sup_hi_ok = 1'b0;
    run_len(len);
    chk(len == 8, "R3 upper flag drop ignored", len, 8);

    // R11: undervoltage inside a pulse-low half restarts power-up
    step(2);
    sup_lo_ok = 1'b0;
    step(1);
    chk(rst_n_out == 1'b0, "R11 undervoltage in pulse", int'(rst_n_out), 0);
    delay_cnt = DLY_W'(10);
    sup_lo_ok = 1'b1;
    sup_hi_ok = 1'b1;
    run_len(len);
    chk(len == 11, "R11 full power-up again", len, 11);

    // R9: regular kicks keep reset high
    ok = 1'b1;
    for (int j = 0; j < 10; j++) begin
      wdog_in = 1'b0;
      for (int k = 0; k < 3; k++) begin step(1); if (!rst_n_out) ok = 1'b0; end
      wdog_in = 1'b1;
      for (int k = 0; k < 3; k++) begin step(1); if (!rst_n_out) ok = 1'b0; end
    end
    chk(ok, "R9 serviced stays high", int'(ok), 1);
    run_len(len);
    chk(len == 7, "R8 rising edge ignored", len, 7);

    // R10: falling edge on the first pulse-low sample
    wdog_in = 1'b0;
    step(2);
    chk(rst_n_out == 1'b0, "R9 two-flop latency", int'(rst_n_out), 0);
    step(1);
    chk(rst_n_out == 1'b1, "R10 kick ends pulse", int'(rst_n_out), 1);
    run_len(len);
    chk(len == 10, "R10 fresh window", len, 10);
    run_len(len);
    chk(len == 10, "R8 low level ignored", len, 10);
    wdog_in = 1'b1;
    run_len(len);
    chk(len == 10, "R8 rising in pulse ignored", len, 10);
    run_len(len);

    // R1: asynchronous clear while reset is high
    chk(rst_n_out == 1'b1, "R7 back to high half", int'(rst_n_out), 1);
    por_clr_n = 1'b0;
    #1;
    chk(rst_n_out == 1'b0, "R1 async clear", int'(rst_n_out), 0);
    step(1);
    por_clr_n = 1'b1;
    run_len(len);
    chk(len == 11, "R1 power-up after clear", len, 11);

    finish_up();
  end
endmodule